// File: doc/BRIEF.md
# SPI Register Interface with Deferred Write Commit

This block is an SPI slave that gives a host byte-wide access to a small bank of 8-bit control registers and three read-only, sticky status registers. The host lowers chip-select, shifts command bytes in MSB first (mode 0), and raises chip-select to end the frame. Every byte the block shifts out carries the response to the command byte received before it. The host therefore sends a trailing dummy byte to collect the last response.

Writes do not take effect when their data byte arrives. The block holds each write as pending and commits it on the chip-select rising edge. A write is committed only if it was the final, complete command of the frame. Status registers capture error inputs only while chip-select is high, so they stay frozen for the whole of a frame. An active-low error output stays low while any status flag is set. A flag clears once its register has been read and chip-select has then risen.

All SPI pins are brought into the system clock domain through synchronisers. The SPI clock must therefore be several times slower than the system clock.

Top module: `spi_regif_top`

## Requirements
- R1: A complete write (command byte with bit 7 = 1 and address in bits 4:0, then a data byte) changes the addressed control register only after chip-select rises. The control outputs keep their old value while chip-select is still low.
- R2: If any command byte is received after a write within the same chip-select low period, the pending write is dropped and the register keeps its previous value.
- R3: Read data is delayed by one byte. During each byte, the data output shifts out the contents, at the time it was received, of the register addressed by the previous command byte of either kind. A write's data byte leaves that response unchanged. Bit 7 = 0 marks a read, bits 6:5 are ignored, and output is MSB first.
- R4: After reset, all control registers and status flags are 0x00, the error output is high, and the first byte shifted out is 0x00.
- R5: A read of a register in the same frame directly after a write to it returns the old contents.
- R6: Status flags sample the error inputs only while chip-select is high. An error that appears while chip-select is low is neither returned by a read in that frame nor shown on the error output until chip-select rises.
- R7: Control registers sit at addresses 0x00 to 0x03 and status registers at 0x04, 0x05 and 0x06, and these can be read back-to-back in one frame. Reads of any other address return 0x00. Writes to status or unmapped addresses change nothing.
- R8: The error output is low while any status flag is set. A status register's flags clear at the first chip-select rise after a read of that register, provided the error source has gone.
- R9: A frame that ends mid-byte, or between a write's command byte and its data byte, commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high-impedance while chip-select is high |
| err_src | input | NUM_STAT*8 | Error inputs, 8 per status register, status register k in bits 8k+7:8k |
| ctrl_q | output | NUM_CTRL*8 | Control register contents, register i in bits 8i+7:8i |
| err_n | output | 1 | Active-low summary of all status flags |

## Verification
The hardest condition to reach from the ports is an error that arises while a frame is in progress. In that case the status read in the same frame must return the frozen, clean value and the error output must not move. The bench reaches it by raising an error input between two bytes of an open frame, reading the status register there and checking both outputs. It then checks that the flag appears only after chip-select rises. It also ends frames after a stray part byte that follows a complete write, to show the commit is blocked. Random frames mix writes, reads and dummy bytes, so that writes followed by further commands are dropped at varied positions.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    // Command byte layout: write flag, two ignored bits, register address
    typedef struct packed {
        logic       wr;
        logic [1:0] unused;
        addr_t      addr;
    } cmd_t;

    // Synchronised SPI pin events in the system clock domain
    typedef struct packed {
        logic cs_hi;
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } spi_ev_t;

    // Write request handed from the command decoder to the register bank
    typedef struct packed {
        logic  valid;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    typedef enum logic {
        PH_CMD,
        PH_DATA
    } phase_e;

    function automatic cmd_t decode_cmd(input byte_t b);
        return cmd_t'(b);
    endfunction

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync
    import spi_regif_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk,
    input  logic    cs_n,
    input  logic    mosi,
    output spi_ev_t ev
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES:0] sck_p;
    logic [STAGES:0] cs_p;
    logic [STAGES:0] mo_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            mo_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sclk};
            cs_p  <= {cs_p[STAGES-1:0], cs_n};
            mo_p  <= {mo_p[STAGES-1:0], mosi};
        end
    end

    always_comb begin
        ev.cs_hi    = cs_p[LAST];
        ev.cs_fall  = cs_p[STAGES] & ~cs_p[LAST];
        ev.cs_rise  = ~cs_p[STAGES] & cs_p[LAST];
        ev.sck_rise = ~sck_p[STAGES] & sck_p[LAST];
        ev.sck_fall = sck_p[STAGES] & ~sck_p[LAST];
        ev.mosi     = mo_p[LAST];
    end

endmodule

// File: rtl/spi_regif_shift.sv
module spi_regif_shift
    import spi_regif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  spi_ev_t ev,
    input  byte_t   resp,
    output logic    byte_done,
    output byte_t   rx_byte,
    output logic    tx_bit,
    output bitcnt_t bit_cnt
);
    byte_t rx_sr;
    byte_t tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else if (ev.cs_hi) begin
            bit_cnt <= '0;
        end else begin
            if (ev.cs_fall) begin
                tx_sr <= resp;
            end
            if (ev.sck_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], ev.mosi};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (ev.sck_fall) begin
                // a wrapped count means a byte just ended: present the next response
                if (bit_cnt == '0) begin
                    tx_sr <= resp;
                end else begin
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign byte_done = ev.sck_rise & ~ev.cs_hi & (bit_cnt == bitcnt_t'(BYTE_W - 1));
    assign rx_byte   = {rx_sr[BYTE_W-2:0], ev.mosi};
    assign tx_bit    = tx_sr[BYTE_W-1];

endmodule

// File: rtl/spi_regif_cmd.sv
module spi_regif_cmd
    import spi_regif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  spi_ev_t ev,
    input  logic    byte_done,
    input  byte_t   rx_byte,
    input  logic    mid_byte,
    input  byte_t   rd_data,
    output addr_t   rd_addr,
    output logic    rd_strobe,
    output byte_t   resp,
    output wr_req_t commit
);
    phase_e  phase;
    wr_req_t pend;
    cmd_t    cmd;

    assign cmd       = decode_cmd(rx_byte);
    assign rd_addr   = cmd.addr;
    assign rd_strobe = byte_done & (phase == PH_CMD) & ~cmd.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CMD;
            pend  <= '0;
            resp  <= '0;
        end else if (ev.cs_rise) begin
            phase      <= PH_CMD;
            pend.valid <= 1'b0;
        end else if (byte_done) begin
            if (phase == PH_CMD) begin
                resp       <= rd_data;
                pend.valid <= 1'b0;
                pend.addr  <= cmd.addr;
                phase      <= cmd.wr ? PH_DATA : PH_CMD;
            end else begin
                pend.data  <= rx_byte;
                pend.valid <= 1'b1;
                phase      <= PH_CMD;
            end
        end
    end

    always_comb begin
        commit       = pend;
        commit.valid = ev.cs_rise & pend.valid & (phase == PH_CMD) & ~mid_byte;
    end

endmodule

// File: rtl/spi_regif_regs.sv
module spi_regif_regs
    import spi_regif_pkg::*;
#(
    parameter int unsigned NUM_CTRL  = 4,
    parameter int unsigned NUM_STAT  = 3,
    parameter int unsigned STAT_BASE = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_hi,
    input  logic                       cs_rise,
    input  wr_req_t                    commit,
    input  addr_t                      rd_addr,
    input  logic                       rd_strobe,
    input  logic [NUM_STAT*BYTE_W-1:0] err_src,
    output byte_t                      rd_data,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q,
    output logic [NUM_STAT*BYTE_W-1:0] flags,
    output logic                       err_n
);
    byte_t ctrl_r [NUM_CTRL];
    byte_t flag_r [NUM_STAT];

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        localparam addr_t A = addr_t'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_r[i] <= '0;
            end else if (commit.valid && commit.addr == A) begin
                ctrl_r[i] <= commit.data;
            end
        end
        assign ctrl_q[i*BYTE_W +: BYTE_W] = ctrl_r[i];
    end

    for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
        localparam addr_t A = addr_t'(STAT_BASE + k);
        logic read_mark;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_r[k] <= '0;
                read_mark <= 1'b0;
            end else if (cs_rise) begin
                if (read_mark) begin
                    flag_r[k] <= '0;
                end
                read_mark <= 1'b0;
            end else if (cs_hi) begin
                flag_r[k] <= flag_r[k] | err_src[k*BYTE_W +: BYTE_W];
            end else if (rd_strobe && rd_addr == A) begin
                read_mark <= 1'b1;
            end
        end
        assign flags[k*BYTE_W +: BYTE_W] = flag_r[k];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (rd_addr == addr_t'(i)) rd_data = ctrl_r[i];
        end
        for (int k = 0; k < NUM_STAT; k++) begin
            if (rd_addr == addr_t'(STAT_BASE + k)) rd_data = flag_r[k];
        end
    end

    assign err_n = ~|flags;

endmodule

// File: rtl/spi_regif_top.sv
module spi_regif_top
    import spi_regif_pkg::*;
#(
    parameter int unsigned NUM_CTRL    = 4,
    parameter int unsigned NUM_STAT    = 3,
    parameter int unsigned STAT_BASE   = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [NUM_STAT*BYTE_W-1:0] err_src,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q,
    output logic                       err_n
);
    spi_ev_t ev;
    logic    byte_done;
    byte_t   rx_byte;
    logic    tx_bit;
    bitcnt_t bit_cnt;
    byte_t   resp;
    byte_t   rd_data;
    addr_t   rd_addr;
    logic    rd_strobe;
    wr_req_t commit;
    logic    cs_hi;
    logic    cs_rise;
    logic [NUM_STAT*BYTE_W-1:0] flags;

    assign cs_hi   = ev.cs_hi;
    assign cs_rise = ev.cs_rise;

    spi_regif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .ev   (ev)
    );

    spi_regif_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .resp      (resp),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_bit    (tx_bit),
        .bit_cnt   (bit_cnt)
    );

    spi_regif_cmd u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .mid_byte  (bit_cnt != '0),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .rd_strobe (rd_strobe),
        .resp      (resp),
        .commit    (commit)
    );

    spi_regif_regs #(
        .NUM_CTRL  (NUM_CTRL),
        .NUM_STAT  (NUM_STAT),
        .STAT_BASE (STAT_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cs_hi     (cs_hi),
        .cs_rise   (cs_rise),
        .commit    (commit),
        .rd_addr   (rd_addr),
        .rd_strobe (rd_strobe),
        .err_src   (err_src),
        .rd_data   (rd_data),
        .ctrl_q    (ctrl_q),
        .flags     (flags),
        .err_n     (err_n)
    );

    assign spi_miso = cs_hi ? 1'bz : tx_bit;

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk
    import spi_regif_pkg::*;
#(
    parameter int unsigned CW = 32,
    parameter int unsigned FW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_hi,
    input logic          cs_rise,
    input bitcnt_t       bit_cnt,
    input logic          byte_done,
    input byte_t         resp,
    input logic [CW-1:0] ctrl_q,
    input logic [FW-1:0] flags
);
    // R1: control registers move only in the cycle after a chip-select rise
    a_r1_ctrl_moves_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(cs_rise));

    // R9: a frame ending mid-byte leaves control registers untouched
    a_r9_partial_no_commit: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && bit_cnt != '0) |=> $stable(ctrl_q));

    // R3: the response register changes only when a byte completes
    a_r3_resp_on_byte: assert property (@(posedge clk) disable iff (rst)
        !$stable(resp) |-> $past(byte_done));

    // R6: a flag can newly set only from a cycle with chip-select high
    a_r6_flag_set_when_high: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags)) != '0) |-> $past(cs_hi));

    // R8: a flag can clear only at a chip-select rise
    a_r8_flag_clear_on_rise: assert property (@(posedge clk) disable iff (rst)
        ((~flags & $past(flags)) != '0) |-> $past(cs_rise));

endmodule

bind spi_regif_top spi_regif_chk #(
    .CW (NUM_CTRL * spi_regif_pkg::BYTE_W),
    .FW (NUM_STAT * spi_regif_pkg::BYTE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_hi     (cs_hi),
    .cs_rise   (cs_rise),
    .bit_cnt   (bit_cnt),
    .byte_done (byte_done),
    .resp      (resp),
    .ctrl_q    (ctrl_q),
    .flags     (flags)
);

// File: tb/spi_regif_top_test.sv
module spi_regif_top_test;
    localparam int HALF = 6;
    localparam int NC   = 4;
    localparam int NS   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic [NS*8-1:0] err_src = '0;
    logic [NC*8-1:0] ctrl_q;
    logic err_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NC*8-1:0] m_ctrl = '0;
    logic [NS*8-1:0] m_flag = '0;
    logic [NS-1:0]   m_mark = '0;
    logic [7:0]      m_resp = '0;
    logic            m_pend = 1'b0;
    logic [4:0]      m_paddr = '0;
    logic [7:0]      m_pdata = '0;

    always #10 clk = ~clk;

    spi_regif_top uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .err_src(err_src),
        .ctrl_q(ctrl_q), .err_n(err_n)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [4:0] a);
        if (a < 5'(NC)) return m_ctrl[a*8 +: 8];
        if (a >= 5'd4 && a < 5'd7) return m_flag[(a-5'd4)*8 +: 8];
        return 8'h00;
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic part_bits(input int n, input logic [7:0] tx);
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_begin();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // mid: frame ended inside a byte
    task automatic frame_end(input bit mid);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        if (m_pend && !mid && m_paddr < 5'(NC)) m_ctrl[m_paddr*8 +: 8] = m_pdata;
        m_pend = 1'b0;
        for (int k = 0; k < NS; k++) if (m_mark[k]) m_flag[k*8 +: 8] = 8'h00;
        m_mark = '0;
        m_flag = m_flag | err_src;
        repeat (12) @(negedge clk);
        chk("R1 ctrl after frame", ctrl_q, m_ctrl);
    endtask

    task automatic op_read(input logic [4:0] a, input string tag);
        logic [7:0] rx;
        xfer({3'b000, a}, rx);
        chk(tag, rx, m_resp);
        m_resp = m_read(a);
        m_pend = 1'b0;
        if (a >= 5'd4 && a < 5'd7) m_mark[a - 5'd4] = 1'b1;
    endtask

    task automatic op_write(input logic [4:0] a, input logic [7:0] d, input string tag);
        logic [7:0] rx;
        xfer({3'b100, a}, rx);
        chk(tag, rx, m_resp);
        m_resp = m_read(a);
        m_pend = 1'b0;
        m_paddr = a;
        xfer(d, rx);
        chk(tag, rx, m_resp);
        m_pdata = d;
        m_pend = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        void'($urandom(32'h1D2C3B4A));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R4: reset state
        chk("R4 ctrl reset", ctrl_q, '0);
        chk("R4 err_n reset", {31'd0, err_n}, 32'd1);
        frame_begin();
        op_read(5'd0, "R4 first byte after reset");
        op_read(5'h1F, "R3 response of read 0x00");
        frame_end(1'b0);

        // R1: write commits only at chip-select rise
        frame_begin();
        op_write(5'd1, 8'hA5, "R3 write bytes");
        repeat (8) @(negedge clk);
        chk("R1 ctrl held while cs low", ctrl_q, '0);
        frame_end(1'b0);
        chk("R1 committed value", ctrl_q[15:8], 8'hA5);

        // R2 / R5: write then read same register in one frame
        frame_begin();
        op_write(5'd1, 8'h3C, "R3 write bytes");
        op_read(5'd1, "R5 read cmd byte");
        op_read(5'h1F, "R5 old contents after write");
        frame_end(1'b0);
        chk("R2 write dropped", ctrl_q[15:8], 8'hA5);

        // R7: write to status and unmapped ignored, unmapped read is zero
        frame_begin();
        op_write(5'd5, 8'hFF, "R7 write status");
        frame_end(1'b0);
        frame_begin();
        op_write(5'd9, 8'h77, "R7 write unmapped");
        frame_end(1'b0);
        chk("R7 err_n after status write", {31'd0, err_n}, 32'd1);
        frame_begin();
        op_read(5'd9, "R7 read unmapped cmd");
        op_read(5'd5, "R7 unmapped reads zero");
        op_read(5'h1F, "R7 status untouched by write");
        frame_end(1'b0);

        // R9: frame ends between command and data, and after a stray part byte
        frame_begin();
        xfer(8'h82, rx);
        m_resp = m_read(5'd2);
        frame_end(1'b0);
        chk("R9 no commit without data", ctrl_q[23:16], 8'h00);
        frame_begin();
        op_write(5'd2, 8'h5A, "R3 write bytes");
        part_bits(3, 8'hE0);
        frame_end(1'b1);
        chk("R9 no commit after part byte", ctrl_q[23:16], 8'h00);

        // R6: error arrives inside an open frame
        frame_begin();
        op_read(5'd5, "R3 status read");
        err_src[15:8] = 8'h04;
        repeat (10) @(negedge clk);
        op_read(5'h1F, "R6 status frozen in frame");
        chk("R6 err_n unmoved in frame", {31'd0, err_n}, 32'd1);
        m_mark = '0;
        frame_end(1'b0);
        chk("R6 flag after cs rise", {31'd0, err_n}, 32'd0);
        err_src = '0;
        repeat (4) @(negedge clk);

        // R7 / R8: back-to-back status reads, selective clearing
        err_src[7:0] = 8'h81;
        repeat (10) @(negedge clk);
        m_flag = m_flag | err_src;
        err_src = '0;
        frame_begin();
        op_read(5'd4, "R7 status 0x04");
        op_read(5'd5, "R7 status 0x04 data");
        op_read(5'd6, "R7 status 0x05 data");
        op_read(5'h1F, "R7 status 0x06 data");
        chk("R8 err_n low before cs rise", {31'd0, err_n}, 32'd0);
        frame_end(1'b0);
        chk("R8 err_n high after reading all", {31'd0, err_n}, 32'd1);
        err_src = 24'h020010;
        repeat (10) @(negedge clk);
        m_flag = m_flag | err_src;
        err_src = '0;
        frame_begin();
        op_read(5'd4, "R8 read one of two");
        frame_end(1'b0);
        chk("R8 err_n low with flag left", {31'd0, err_n}, 32'd0);
        frame_begin();
        op_read(5'd6, "R8 read 0x06 flag");
        op_read(5'h1F, "R8 0x06 contents");
        frame_end(1'b0);
        chk("R8 err_n high after last", {31'd0, err_n}, 32'd1);

        // random frames
        for (int f = 0; f < 110; f++) begin
            int nops;
            nops = 1 + int'($urandom % 4);
            frame_begin();
            for (int o = 0; o < nops; o++) begin
                int kind;
                kind = int'($urandom % 5);
                case (kind)
                    0, 1: op_write(5'($urandom % NC), 8'($urandom), "R2 random write");
                    2: op_read(5'($urandom % NC), "R3 random read");
                    3: op_read(5'd4 + 5'($urandom % 3), "R7 random status read");
                    default: op_read(5'd7 + 5'($urandom % 25), "R7 random unmapped read");
                endcase
            end
            if ($urandom % 8 == 0) begin
                part_bits(1 + int'($urandom % 7), 8'($urandom));
                frame_end(1'b1);
            end else begin
                frame_end(1'b0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule